// File: doc/BRIEF.md
# Condition code flag unit

This block owns an 8-bit condition code register. Arithmetic logic elsewhere in the datapath produces a result together with its two operands. Each cycle it can hand these to the unit along with an operation class and a width select. The unit then works out the negative, zero, overflow and carry flags for that class and writes back only the flags the class is allowed to change. The four remaining bits (interrupt mask, half carry, the second interrupt mask and the stop disable) are never computed here. They change only through software-style writes.

Control logic can also load the whole register in one cycle, or set or clear one selected bit. The register output is the flag state that branch and interrupt logic read. It reflects an update on the clock edge after the request. Operands may be 8 or 16 bits wide. In 8-bit mode the upper byte of the result and of both operands is ignored.

Top module: `ccr_flag_unit`

## Requirements
- R1: While reset is held low, and after it is released with no request, `ccr` reads 0xD0. Bit positions are C=0, V=1, Z=2, N=3, I=4, H=5, X=6, S=7, so only S, X and I are set.
- R2: With `wr_en` high, `ccr` equals `wr_data` after the next rising clock edge.
- R3: With `bit_en` high and `wr_en` low, bit `bit_sel` of `ccr` takes the value `bit_val` after the next edge, and every other bit keeps its value.
- R4: Requests are prioritised with `wr_en` first, then `bit_en`, then `op_valid`. In a given cycle only the highest-priority request takes effect, and the lower ones are dropped.
- R5: For `op_class` = 0 (add), C = msb((a&b)|(b&~r)|(a&~r)), V = msb((a&b&~r)|(~a&~b&r)), N = msb(r) and Z = (r == 0).
- R6: For `op_class` = 1 (subtract), C = msb((~a&b)|(b&r)|(~a&r)), V = msb((a&~b&~r)|(~a&b&r)), N = msb(r) and Z = (r == 0).
- R7: For `op_class` = 2 (test), V is cleared, N and Z follow the result, and C keeps its value.
- R8: For `op_class` = 3 (shift), N and Z follow the result, V becomes the new N XOR the C already held in the register, and C keeps its value.
- R9: msb means bit 15 when `op_wide` is 1 and bit 7 when it is 0. In 8-bit mode, Z looks only at the low byte of the result, and bits 15..8 of all three inputs have no effect.
- R10: No operation class changes bits 7..4 (S, X, H, I).
- R11: When none of `wr_en`, `bit_en` or `op_valid` is high, `ccr` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| op_valid | input | 1 | Apply a flag update from the operation inputs this cycle |
| op_class | input | 2 | 0 add, 1 subtract, 2 test, 3 shift |
| op_wide | input | 1 | 1 selects 16-bit evaluation, 0 selects 8-bit |
| op_res | input | DATA_W | Result r of the operation |
| op_a | input | DATA_W | First operand a |
| op_b | input | DATA_W | Second operand b |
| wr_en | input | 1 | Load the whole register from wr_data |
| wr_data | input | 8 | Value for a whole-register load |
| bit_en | input | 1 | Write one selected bit |
| bit_sel | input | 3 | Position of the bit to write |
| bit_val | input | 1 | Value for the selected bit |
| ccr | output | 8 | Current condition code register |

## Verification
`ccr` is the register itself, so a wrong flag shows up at the port on the edge right after the faulty update. It does not wait for a later use. A stale or corrupted carry is the exception. Test and shift pass it through unchanged, and a shift also folds it into V, so the corruption can spread into the overflow bit on a later shift. The sweeps therefore keep a running expected register rather than a fresh one per step. A wrong width select or lane zero detector shows up as a Z or N mismatch on results whose upper byte differs from the lower.

// File: rtl/ccr_pkg.sv
package ccr_pkg;

  localparam int unsigned CCR_W = 8;
  localparam int unsigned SEL_W = $clog2(CCR_W);

  localparam int unsigned POS_C = 0;
  localparam int unsigned POS_V = 1;
  localparam int unsigned POS_Z = 2;
  localparam int unsigned POS_N = 3;
  localparam int unsigned POS_I = 4;
  localparam int unsigned POS_H = 5;
  localparam int unsigned POS_X = 6;
  localparam int unsigned POS_S = 7;

  localparam logic [CCR_W-1:0] CCR_RESET = 8'hD0;

  typedef enum logic [1:0] {
    CLS_ADD = 2'd0,
    CLS_SUB = 2'd1,
    CLS_TST = 2'd2,
    CLS_SHF = 2'd3
  } op_cls_e;

  // arithmetic flags in register order, highest first
  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } arith_t;

endpackage

// File: rtl/ccr_msb_zero.sv
module ccr_msb_zero #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned LANE_W = 8
) (
  input  logic [DATA_W-1:0] vec,
  input  logic              wide,
  output logic              msb,
  output logic              zero
);

  localparam int unsigned LANES = DATA_W / LANE_W;

  logic [LANES-1:0] lane_nz;

  genvar g;
  generate
    for (g = 0; g < LANES; g++) begin : g_lane
      assign lane_nz[g] = |vec[g*LANE_W +: LANE_W];
    end
  endgenerate

  always_comb begin
    if (wide) begin
      msb  = vec[DATA_W-1];
      zero = ~|lane_nz;
    end else begin
      msb  = vec[LANE_W-1];
      zero = ~lane_nz[0];
    end
  end

endmodule

// File: rtl/ccr_flag_logic.sv
module ccr_flag_logic
  import ccr_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned LANE_W = 8
) (
  input  op_cls_e           cls,
  input  logic              wide,
  input  logic [DATA_W-1:0] res,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  logic              c_now,
  output arith_t            flags,
  output logic [3:0]        upd
);

  logic r_msb, r_zero;
  logic a_msb, a_zero_unused;
  logic b_msb, b_zero_unused;

  ccr_msb_zero #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_res (
    .vec(res), .wide(wide), .msb(r_msb), .zero(r_zero)
  );
  ccr_msb_zero #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_opa (
    .vec(opa), .wide(wide), .msb(a_msb), .zero(a_zero_unused)
  );
  ccr_msb_zero #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_opb (
    .vec(opb), .wide(wide), .msb(b_msb), .zero(b_zero_unused)
  );

  // carry and overflow depend only on the sign bits of a, b and r
  logic add_c, add_v, sub_c, sub_v;

  always_comb begin
    add_c = (a_msb & b_msb) | (b_msb & ~r_msb) | (a_msb & ~r_msb);
    add_v = (a_msb & b_msb & ~r_msb) | (~a_msb & ~b_msb & r_msb);
    sub_c = (~a_msb & b_msb) | (b_msb & r_msb) | (~a_msb & r_msb);
    sub_v = (a_msb & ~b_msb & ~r_msb) | (~a_msb & b_msb & r_msb);
  end

  always_comb begin
    flags.n = r_msb;
    flags.z = r_zero;
    flags.v = 1'b0;
    flags.c = c_now;
    upd     = 4'b1110;
    unique case (cls)
      CLS_ADD: begin
        flags.v = add_v;
        flags.c = add_c;
        upd     = 4'b1111;
      end
      CLS_SUB: begin
        flags.v = sub_v;
        flags.c = sub_c;
        upd     = 4'b1111;
      end
      CLS_TST: begin
        flags.v = 1'b0;
      end
      CLS_SHF: begin
        flags.v = r_msb ^ c_now;
      end
      default: begin
        flags.v = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/ccr_state_reg.sv
module ccr_state_reg
  import ccr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_all,
  input  logic [CCR_W-1:0] ld_data,
  input  logic             bit_en,
  input  logic [SEL_W-1:0] bit_sel,
  input  logic             bit_val,
  input  logic             op_en,
  input  logic [3:0]       upd,
  input  arith_t           flags,
  output logic [CCR_W-1:0] ccr_q
);

  logic [CCR_W-1:0] ccr_d;
  logic             ccr_en;
  logic [CCR_W-1:0] sel_mask;

  always_comb begin
    sel_mask = '0;
    sel_mask[bit_sel] = 1'b1;
  end

  always_comb begin
    ccr_en = ld_all | bit_en | op_en;
    ccr_d  = ccr_q;
    if (ld_all) begin
      ccr_d = ld_data;
    end else if (bit_en) begin
      // clear the selected bit, then OR the new value back in
      ccr_d = (ccr_q & ~sel_mask) | (bit_val ? sel_mask : '0);
    end else if (op_en) begin
      if (upd[3]) ccr_d[POS_N] = flags.n;
      if (upd[2]) ccr_d[POS_Z] = flags.z;
      if (upd[1]) ccr_d[POS_V] = flags.v;
      if (upd[0]) ccr_d[POS_C] = flags.c;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ccr_q <= CCR_RESET;
    end else if (ccr_en) begin
      ccr_q <= ccr_d;
    end
  end

endmodule

// File: rtl/ccr_flag_unit.sv
module ccr_flag_unit
  import ccr_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned LANE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             op_valid,
  input  logic [1:0]       op_class,
  input  logic             op_wide,
  input  logic [DATA_W-1:0] op_res,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  input  logic             wr_en,
  input  logic [CCR_W-1:0] wr_data,
  input  logic             bit_en,
  input  logic [SEL_W-1:0] bit_sel,
  input  logic             bit_val,
  output logic [CCR_W-1:0] ccr
);

  arith_t     fl;
  logic [3:0] fl_upd;
  logic       bit_go;
  logic       op_go;

  // priority: whole load, then single bit, then operation
  assign bit_go = bit_en & ~wr_en;
  assign op_go  = op_valid & ~wr_en & ~bit_en;

  ccr_flag_logic #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_logic (
    .cls   (op_cls_e'(op_class)),
    .wide  (op_wide),
    .res   (op_res),
    .opa   (op_a),
    .opb   (op_b),
    .c_now (ccr[POS_C]),
    .flags (fl),
    .upd   (fl_upd)
  );

  ccr_state_reg u_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .ld_all  (wr_en),
    .ld_data (wr_data),
    .bit_en  (bit_go),
    .bit_sel (bit_sel),
    .bit_val (bit_val),
    .op_en   (op_go),
    .upd     (fl_upd),
    .flags   (fl),
    .ccr_q   (ccr)
  );

endmodule

// File: rtl/ccr_flag_unit_chk.sv
module ccr_flag_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       op_valid,
  input logic [1:0] op_class,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic       bit_en,
  input logic [2:0] bit_sel,
  input logic       bit_val,
  input logic [7:0] ccr
);

  logic op_only;
  assign op_only = op_valid & ~wr_en & ~bit_en;

  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !bit_en && !op_valid) |=> $stable(ccr));

  assert_full_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (ccr == $past(wr_data)));

  assert_bit_value_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && !wr_en) |=> (ccr[$past(bit_sel)] == $past(bit_val)));

  assert_bit_others_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && !wr_en) |=>
      (((ccr ^ $past(ccr)) & ~(8'h01 << $past(bit_sel))) == 8'h00));

  assert_bit_beats_op_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && !wr_en && op_valid) |=> ($countones(ccr ^ $past(ccr)) <= 1));

  assert_upper_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    op_only |=> (ccr[7:4] == $past(ccr[7:4])));

  assert_test_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_only && op_class == 2'd2) |=> (!ccr[1] && ccr[0] == $past(ccr[0])));

  assert_shift_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_only && op_class == 2'd3) |=>
      ((ccr[1] == (ccr[3] ^ ccr[0])) && ccr[0] == $past(ccr[0])));

endmodule

bind ccr_flag_unit ccr_flag_unit_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .op_valid (op_valid),
  .op_class (op_class),
  .wr_en    (wr_en),
  .wr_data  (wr_data),
  .bit_en   (bit_en),
  .bit_sel  (bit_sel),
  .bit_val  (bit_val),
  .ccr      (ccr)
);

// File: tb/test_ccr_flag_unit.sv
module test_ccr_flag_unit;

  localparam int CLK_PERIOD = 10;
  localparam int DATA_W     = 16;
  localparam int LANE_W     = 8;

  logic              clk;
  logic              rst_n;
  logic              op_valid;
  logic [1:0]        op_class;
  logic              op_wide;
  logic [DATA_W-1:0] op_res;
  logic [DATA_W-1:0] op_a;
  logic [DATA_W-1:0] op_b;
  logic              wr_en;
  logic [7:0]        wr_data;
  logic              bit_en;
  logic [2:0]        bit_sel;
  logic              bit_val;
  logic [7:0]        ccr;

  int         errors = 0;
  int         checks = 0;
  logic [7:0] exp_ccr;
  bit         done = 0;

  ccr_flag_unit #(.DATA_W(DATA_W), .LANE_W(LANE_W)) i_ccr_flag_unit (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_class(op_class),
    .op_wide(op_wide), .op_res(op_res), .op_a(op_a), .op_b(op_b),
    .wr_en(wr_en), .wr_data(wr_data), .bit_en(bit_en), .bit_sel(bit_sel),
    .bit_val(bit_val), .ccr(ccr)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [7:0] expv);
    checks++;
    if (ccr !== expv) begin
      errors++;
      $display("FAIL %s: ccr=%02h expected=%02h", tag, ccr, expv);
    end
  endtask

  // expected flags from plain arithmetic on the masked operands
  function automatic logic [7:0] model(input logic [7:0] cur, input logic [1:0] cls,
                                       input logic wide, input logic [15:0] r,
                                       input logic [15:0] a, input logic [15:0] b);
    logic [7:0]  nx;
    int unsigned w;
    logic [16:0] mask, ma, mb, mr, tmp;
    logic        sa, sb, sr, nn, zz, vv, cc;
    nx   = cur;
    w    = wide ? 16 : 8;
    mask = wide ? 17'h0FFFF : 17'h000FF;
    ma   = {1'b0, a} & mask;
    mb   = {1'b0, b} & mask;
    mr   = {1'b0, r} & mask;
    sa   = ma[w-1];
    sb   = mb[w-1];
    sr   = mr[w-1];
    nn   = sr;
    zz   = (mr == 17'd0);
    tmp  = ma + mb;
    vv   = 1'b0;
    cc   = cur[0];
    case (cls)
      2'd0: begin cc = tmp[w]; vv = (sa == sb) && (sr != sa); end
      2'd1: begin cc = (ma < mb); vv = (sa != sb) && (sr != sa); end
      2'd2: begin vv = 1'b0; end
      default: begin vv = nn ^ cur[0]; end
    endcase
    nx[3] = nn;
    nx[2] = zz;
    nx[1] = vv;
    nx[0] = cc;
    return nx;
  endfunction

  task automatic clear_inputs();
    op_valid = 1'b0; op_class = 2'd0; op_wide = 1'b0;
    op_res = '0; op_a = '0; op_b = '0;
    wr_en = 1'b0; wr_data = '0; bit_en = 1'b0; bit_sel = '0; bit_val = 1'b0;
  endtask

  task automatic run_op(input logic [1:0] cls, input logic wide, input logic [15:0] r,
                        input logic [15:0] a, input logic [15:0] b, input string tag);
    op_valid = 1'b1; op_class = cls; op_wide = wide;
    op_res = r; op_a = a; op_b = b;
    @(negedge clk);
    op_valid = 1'b0;
    exp_ccr = model(exp_ccr, cls, wide, r, a, b);
    check(tag, exp_ccr);
  endtask

  task automatic do_write(input logic [7:0] v, input string tag);
    wr_en = 1'b1; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
    exp_ccr = v;
    check(tag, exp_ccr);
  endtask

  task automatic do_bit(input logic [2:0] sel, input logic val, input string tag);
    bit_en = 1'b1; bit_sel = sel; bit_val = val;
    @(negedge clk);
    bit_en = 1'b0;
    exp_ccr[sel] = val;
    check(tag, exp_ccr);
  endtask

  function automatic logic [15:0] corner(input int k);
    case (k)
      0: return 16'h0000;
      1: return 16'h0001;
      2: return 16'h7FFF;
      3: return 16'h8000;
      4: return 16'hFFFF;
      5: return 16'h00FF;
      default: return 16'h0080;
    endcase
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    clear_inputs();
    rst_n = 1'b0;
    exp_ccr = 8'hD0;
    repeat (3) @(negedge clk);
    check("R1 during reset", 8'hD0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", 8'hD0);

    // R11: no request keeps the reset value
    repeat (3) begin
      @(negedge clk);
      check("R11 idle after reset", exp_ccr);
    end

    // R2: every whole-register value
    for (int v = 0; v < 256; v++) do_write(8'(v), "R2 whole write");

    // R3: each bit both ways from several start patterns
    for (int p = 0; p < 4; p++) begin
      do_write((p == 0) ? 8'h00 : (p == 1) ? 8'hFF : (p == 2) ? 8'h5A : 8'hA5, "R2 preset");
      for (int s = 0; s < 8; s++) begin
        do_bit(3'(s), 1'b1, "R3 bit set");
        do_bit(3'(s), 1'b0, "R3 bit clear");
        do_bit(3'(s), 1'b1, "R3 bit set again");
      end
    end

    // R4: all three at once, whole load wins
    wr_en = 1'b1; wr_data = 8'h3C;
    bit_en = 1'b1; bit_sel = 3'd0; bit_val = 1'b1;
    op_valid = 1'b1; op_class = 2'd0; op_wide = 1'b0;
    op_a = 16'h0080; op_b = 16'h0080; op_res = 16'h0000;
    @(negedge clk);
    clear_inputs();
    exp_ccr = 8'h3C;
    check("R4 load beats bit and op", exp_ccr);
    // R4: bit write beats op (test of 0x01 would clear Z)
    bit_en = 1'b1; bit_sel = 3'd0; bit_val = 1'b1;
    op_valid = 1'b1; op_class = 2'd2; op_wide = 1'b0; op_res = 16'h0001;
    @(negedge clk);
    clear_inputs();
    exp_ccr = 8'h3D;
    check("R4 bit beats op", exp_ccr);

    // R5/R9/R10: 8-bit add sweep with garbage upper bytes
    do_write(8'hA0, "R2 preset upper");
    for (int b = 0; b < 256; b++) begin
      for (int a = 0; a < 256; a += 15) begin
        run_op(2'd0, 1'b0,
               {8'(a ^ b ^ 8'h5A), 8'(a + b)},
               {8'(~a), 8'(a)}, {8'(b + 3), 8'(b)},
               "R5/R9/R10 add 8-bit");
      end
    end
    // R5/R9: 16-bit add corners and patterns
    for (int i = 0; i < 7; i++)
      for (int j = 0; j < 7; j++)
        run_op(2'd0, 1'b1, 16'(corner(i) + corner(j)), corner(i), corner(j), "R5/R9 add 16-bit corner");
    for (int i = 0; i < 1024; i++) begin
      logic [15:0] a16, b16;
      a16 = 16'(i * 97) ^ 16'(i << 6);
      b16 = ~16'(i * 131);
      run_op(2'd0, 1'b1, a16 + b16, a16, b16, "R5/R9 add 16-bit");
    end

    // R6/R9/R10: subtract
    do_write(8'h50, "R2 preset upper");
    for (int b = 0; b < 256; b++) begin
      for (int a = 0; a < 256; a += 15) begin
        run_op(2'd1, 1'b0,
               {8'(a + 8'h33), 8'(a - b)},
               {8'(b), 8'(a)}, {8'(~b), 8'(b)},
               "R6/R9/R10 sub 8-bit");
      end
    end
    for (int i = 0; i < 7; i++)
      for (int j = 0; j < 7; j++)
        run_op(2'd1, 1'b1, 16'(corner(i) - corner(j)), corner(i), corner(j), "R6/R9 sub 16-bit corner");
    for (int i = 0; i < 1024; i++) begin
      logic [15:0] a16, b16;
      a16 = 16'(i * 211) ^ 16'(i << 5);
      b16 = 16'(i * 59) ^ 16'hA5C3;
      run_op(2'd1, 1'b1, a16 - b16, a16, b16, "R6/R9 sub 16-bit");
    end

    // R7/R9: test, starting with V and C set
    for (int c = 0; c < 2; c++) begin
      do_write(c ? 8'hF3 : 8'h02, "R2 preset test");
      run_op(2'd2, 1'b0, 16'h8000, 16'h1234, 16'hFFFF, "R7/R9 test 8-bit upper only");
      do_bit(3'd1, 1'b1, "R3 set V");
      run_op(2'd2, 1'b0, 16'h0080, 16'h0000, 16'h0000, "R7/R9 test 8-bit neg");
      run_op(2'd2, 1'b0, 16'hFF7F, 16'h0000, 16'h0000, "R7/R9 test 8-bit pos");
      run_op(2'd2, 1'b1, 16'h0080, 16'h0000, 16'h0000, "R7/R9 test 16-bit pos");
      run_op(2'd2, 1'b1, 16'h8000, 16'h0000, 16'h0000, "R7/R9 test 16-bit neg");
      run_op(2'd2, 1'b1, 16'h0000, 16'hFFFF, 16'hFFFF, "R7/R9 test 16-bit zero");
      run_op(2'd2, 1'b1, 16'h0100, 16'h0000, 16'h0000, "R7/R9 test 16-bit upper");
    end

    // R8: shift with C clear then set, both widths
    for (int c = 0; c < 2; c++) begin
      do_bit(3'd0, 1'(c), "R3 preset C");
      for (int k = 0; k < 7; k++) begin
        run_op(2'd3, 1'b0, corner(k), 16'hFFFF, 16'h0000, "R8/R9 shift 8-bit");
        run_op(2'd3, 1'b1, corner(k), 16'h0000, 16'hFFFF, "R8/R9 shift 16-bit");
      end
    end

    // R11: hold with no request
    repeat (5) begin
      @(negedge clk);
      check("R11 idle hold", exp_ccr);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule